// File: doc/BRIEF.md
# Segmented Ternary Match Engine

This block is a small ternary match array for packet classification. Storage is a set of narrow rows. Each row holds a data word, a per-bit care mask and a valid bit. Rows are grouped into fixed-size segments. Static configuration gives each segment an owning database and an enable. It also gives each database a core width, which sets how many consecutive rows make up one entry (1, 2, 4, 8 or 16 rows of 36 bits, that is 36 to 576 bits). A database can own several segments, and the smallest database is one whole segment.

A search names a database, presents a key and picks a global mask register by a 5-bit selector. The selected register is ANDed into both the key and every stored row before comparison. Each database has a configuration bit that decides which half of the 64 global mask registers its selectors address. The all-ones selector means that no global mask is applied. The engine reports:

- a hit flag;
- a multi-hit flag;
- the absolute row index of the winning entry;
- the same entry's index counted within the database.

Among several matching entries the one at the lowest position wins. Longest-prefix tables therefore work by storing longer prefixes first, each with a mask whose high-order prefix bits are set.

Top module: `tern_match_engine`

## Requirements
- R1: A search considers only entries in segments that are enabled and mapped to the named database (segment s uses cfgSegDb[s*2 +: 2]). A database with no such segment never hits. Configuration is changed only while no search is in flight.
- R2: Width code w of a database (cfgDbWidth[db*3 +: 3], values 0..4) makes each entry 2^w consecutive rows, starting at a row index that is a multiple of 2^w. Row k of an entry compares against key bits [k*36 +: 36]. Entry validity is the valid bit of its first row. A code above 4 never hits.
- R3: A stored mask bit of 0 makes that bit a don't-care. A bit of 1 requires the key bit to equal the data bit.
- R4: When several entries match, the lowest row index is reported. A longest-prefix table stored longest-first therefore returns the longest matching prefix.
- R5: resMultiHit is 1 exactly when at least two entries of the database match.
- R6: The global mask register used is number 32*cfgDbGmrHalf[db] + srchGmrSel. Selector 31 applies no global mask. A global mask bit of 0 is a don't-care. Register writes use gmrWrAddr with the same numbering. After reset all registers are all-ones.
- R7: A miss gives resHit=0, resMultiHit=0, resIndex=0 and resRelIndex=0.
- R8: A result appears with resValid two clock edges after the edge that takes srchValid. A row or register write presented in the same cycle as the search is seen by it. A write presented one cycle later is not.
- R9: After reset resValid is 0 and every row is invalid, so searches miss until rows are written.
- R10: resRelIndex equals the winning row's offset in its segment plus 16 times the number of the database's segments at lower segment numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSegEnable | input | 4 | Per-segment enable |
| cfgSegDb | input | 8 | Owning database of each segment, 2 bits per segment |
| cfgDbWidth | input | 12 | Width code per database, 3 bits each |
| cfgDbGmrHalf | input | 4 | Global-mask half per database |
| rowWrEn | input | 1 | Row write strobe |
| rowWrAddr | input | 6 | Row to write |
| rowWrData | input | 36 | Row data |
| rowWrMask | input | 36 | Row care mask |
| rowWrValid | input | 1 | Row valid bit |
| gmrWrEn | input | 1 | Global mask write strobe |
| gmrWrAddr | input | 6 | Global mask register number |
| gmrWrData | input | 576 | Global mask value |
| srchValid | input | 1 | Search strobe |
| srchDb | input | 2 | Database to search |
| srchKey | input | 576 | Search key |
| srchGmrSel | input | 5 | Global mask selector within the half |
| resValid | output | 1 | Result strobe |
| resHit | output | 1 | Some entry matched |
| resMultiHit | output | 1 | Two or more entries matched |
| resIndex | output | 6 | Absolute row index of the winner |
| resRelIndex | output | 6 | Database-relative index of the winner |

## Verification
The bench targets these corner cases:

- Overlapping ternary entries: a design that picked the highest index instead of the lowest would return a short prefix over a longer one. A design that counted matches badly would drop or invent the multi-hit flag.
- Writes in the same cycle as a search and in the cycle after it: wrong pipeline timing shows up as stale or premature hits.
- Wide entries whose last row mismatches: a design that checked only the first row of an entry would report false hits.
- Databases spread over non-adjacent segments: a wrong relative index or an owner decode that ignores the enable would surface here.
- Global masks taken from the wrong half, or applied on the reserved selector: these turn hits into misses and misses into hits.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int WCODE_W = 3;

  typedef struct packed {
    logic rowWr;
    logic gmrWr;
    logic capture;
    logic resolve;
  } tcmStrobe_t;
endpackage

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowWrEn,
  input  logic       gmrWrEn,
  input  logic       srchValid,
  output tcmStrobe_t stb,
  output logic       resValid
);
  logic stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      resValid    <= 1'b0;
    end else begin
      stage1Valid <= srchValid;
      resValid    <= stage1Valid;
    end
  end

  always_comb begin
    stb.rowWr   = rowWrEn;
    stb.gmrWr   = gmrWrEn;
    stb.capture = srchValid;
    stb.resolve = stage1Valid;
  end
endmodule

// File: rtl/tcm_store.sv
module tcm_store
  import tcm_pkg::*;
#(
  parameter int ROW_W    = 36,
  parameter int NUM_ROWS = 64,
  parameter int KEY_W    = 576,
  parameter int NUM_GMR  = 64,
  localparam int ROW_IDX_W = $clog2(NUM_ROWS),
  localparam int GMR_IDX_W = $clog2(NUM_GMR)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tcmStrobe_t                stb,
  input  logic [ROW_IDX_W-1:0]      rowWrAddr,
  input  logic [ROW_W-1:0]          rowWrData,
  input  logic [ROW_W-1:0]          rowWrMask,
  input  logic                      rowWrValid,
  input  logic [GMR_IDX_W-1:0]      gmrWrAddr,
  input  logic [KEY_W-1:0]          gmrWrData,
  input  logic [GMR_IDX_W-1:0]      gmrRdIdx,
  output logic [NUM_ROWS*ROW_W-1:0] rowDataFlat,
  output logic [NUM_ROWS*ROW_W-1:0] rowMaskFlat,
  output logic [NUM_ROWS-1:0]       rowValidVec,
  output logic [KEY_W-1:0]          gmrRdData
);
  logic [ROW_W-1:0] dataMem [NUM_ROWS];
  logic [ROW_W-1:0] maskMem [NUM_ROWS];
  logic [KEY_W-1:0] gmrMem  [NUM_GMR];

  always_ff @(posedge clk) begin
    if (stb.rowWr) begin
      dataMem[rowWrAddr] <= rowWrData;
      maskMem[rowWrAddr] <= rowWrMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowValidVec <= '0;
    end else if (stb.rowWr) begin
      rowValidVec[rowWrAddr] <= rowWrValid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GMR; g++) gmrMem[g] <= '1;
    end else if (stb.gmrWr) begin
      gmrMem[gmrWrAddr] <= gmrWrData;
    end
  end

  assign gmrRdData = gmrMem[gmrRdIdx];

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_flat
    assign rowDataFlat[r*ROW_W +: ROW_W] = dataMem[r];
    assign rowMaskFlat[r*ROW_W +: ROW_W] = maskMem[r];
  end
endmodule

// File: rtl/tcm_match.sv
module tcm_match
  import tcm_pkg::*;
#(
  parameter int ROW_W         = 36,
  parameter int SEG_ROWS      = 16,
  parameter int NUM_SEG       = 4,
  parameter int NUM_DB        = 4,
  parameter int MAX_WIDE_LOG2 = 4,
  parameter int GMR_PER_HALF  = 32,
  localparam int NUM_ROWS  = NUM_SEG * SEG_ROWS,
  localparam int KEY_W     = ROW_W << MAX_WIDE_LOG2,
  localparam int ROW_IDX_W = $clog2(NUM_ROWS),
  localparam int DB_W      = (NUM_DB > 1) ? $clog2(NUM_DB) : 1,
  localparam int GSEL_W    = $clog2(GMR_PER_HALF),
  localparam int GMR_IDX_W = GSEL_W + 1,
  localparam int NUM_MODES = MAX_WIDE_LOG2 + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tcmStrobe_t                stb,
  input  logic [NUM_SEG-1:0]        cfgSegEnable,
  input  logic [NUM_SEG*DB_W-1:0]   cfgSegDb,
  input  logic [NUM_DB*WCODE_W-1:0] cfgDbWidth,
  input  logic [NUM_DB-1:0]         cfgDbGmrHalf,
  input  logic [DB_W-1:0]           srchDb,
  input  logic [KEY_W-1:0]          srchKey,
  input  logic [GSEL_W-1:0]         srchGmrSel,
  input  logic [NUM_ROWS*ROW_W-1:0] rowDataFlat,
  input  logic [NUM_ROWS*ROW_W-1:0] rowMaskFlat,
  input  logic [NUM_ROWS-1:0]       rowValidVec,
  input  logic [KEY_W-1:0]          gmrRdData,
  output logic [GMR_IDX_W-1:0]      gmrRdIdx,
  output logic                      resHit,
  output logic                      resMultiHit,
  output logic [ROW_IDX_W-1:0]      resIndex,
  output logic [ROW_IDX_W-1:0]      resRelIndex
);
  logic [KEY_W-1:0]  keyQ;
  logic [DB_W-1:0]   dbQ;
  logic [GSEL_W-1:0] gselQ;

  // stage 1: hold the search request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ  <= '0;
      dbQ   <= '0;
      gselQ <= '0;
    end else if (stb.capture) begin
      keyQ  <= srchKey;
      dbQ   <= srchDb;
      gselQ <= srchGmrSel;
    end
  end

  // global mask fetched in stage 2 so same-cycle register writes are seen
  logic [KEY_W-1:0] effMask;
  assign gmrRdIdx = {cfgDbGmrHalf[dbQ], gselQ};
  assign effMask  = (&gselQ) ? '1 : gmrRdData;

  // per-segment ownership and width mode
  logic [DB_W-1:0]    segOwner [NUM_SEG];
  logic [WCODE_W-1:0] segMode  [NUM_SEG];
  logic [NUM_SEG-1:0] ownSeg;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign segOwner[s] = cfgSegDb[s*DB_W +: DB_W];
    assign segMode[s]  = cfgDbWidth[int'(segOwner[s])*WCODE_W +: WCODE_W];
    assign ownSeg[s]   = cfgSegEnable[s] && (segOwner[s] == dbQ);
  end

  // row compares per width mode, grouped into aligned entries
  logic [NUM_ROWS-1:0]  rowEq      [NUM_MODES];
  logic [NUM_MODES-1:0] rowModeHit [NUM_ROWS];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      localparam int OFF = r % (1 << m);
      assign rowEq[m][r] = ~|((keyQ[OFF*ROW_W +: ROW_W] ^ rowDataFlat[r*ROW_W +: ROW_W])
                              & rowMaskFlat[r*ROW_W +: ROW_W]
                              & effMask[OFF*ROW_W +: ROW_W]);
      if (OFF == 0) begin : g_lead
        assign rowModeHit[r][m] = rowValidVec[r] & (&rowEq[m][r +: (1 << m)]);
      end else begin : g_tail
        assign rowModeHit[r][m] = 1'b0;
      end
    end
  end

  logic [NUM_ROWS-1:0] cand;
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_cand
    localparam int SEG = r / SEG_ROWS;
    assign cand[r] = ownSeg[SEG] && (int'(segMode[SEG]) < NUM_MODES)
                     && rowModeHit[r][segMode[SEG]];
  end

  // lowest-index priority, multi-hit and database-relative index
  logic [ROW_IDX_W-1:0] winIdx;
  logic [ROW_IDX_W-1:0] relC;
  logic                 hitC;
  logic                 multiC;
  int                   rankC;

  always_comb begin
    winIdx = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (cand[r]) winIdx = ROW_IDX_W'(r);
    end
    hitC   = |cand;
    multiC = $countones(cand) > 1;
    rankC  = 0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (ownSeg[s] && (s < int'(winIdx) / SEG_ROWS)) rankC = rankC + 1;
    end
    relC = ROW_IDX_W'(rankC * SEG_ROWS + int'(winIdx) % SEG_ROWS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHit      <= 1'b0;
      resMultiHit <= 1'b0;
      resIndex    <= '0;
      resRelIndex <= '0;
    end else if (stb.resolve) begin
      resHit      <= hitC;
      resMultiHit <= multiC;
      resIndex    <= hitC ? winIdx : '0;
      resRelIndex <= hitC ? relC : '0;
    end
  end
endmodule

// File: rtl/tern_match_engine.sv
module tern_match_engine
  import tcm_pkg::*;
#(
  parameter int ROW_W         = 36,
  parameter int SEG_ROWS      = 16,
  parameter int NUM_SEG       = 4,
  parameter int NUM_DB        = 4,
  parameter int MAX_WIDE_LOG2 = 4,
  parameter int GMR_PER_HALF  = 32,
  localparam int NUM_ROWS  = NUM_SEG * SEG_ROWS,
  localparam int KEY_W     = ROW_W << MAX_WIDE_LOG2,
  localparam int ROW_IDX_W = $clog2(NUM_ROWS),
  localparam int DB_W      = (NUM_DB > 1) ? $clog2(NUM_DB) : 1,
  localparam int GSEL_W    = $clog2(GMR_PER_HALF),
  localparam int GMR_IDX_W = GSEL_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SEG-1:0]        cfgSegEnable,
  input  logic [NUM_SEG*DB_W-1:0]   cfgSegDb,
  input  logic [NUM_DB*WCODE_W-1:0] cfgDbWidth,
  input  logic [NUM_DB-1:0]         cfgDbGmrHalf,
  input  logic                      rowWrEn,
  input  logic [ROW_IDX_W-1:0]      rowWrAddr,
  input  logic [ROW_W-1:0]          rowWrData,
  input  logic [ROW_W-1:0]          rowWrMask,
  input  logic                      rowWrValid,
  input  logic                      gmrWrEn,
  input  logic [GMR_IDX_W-1:0]      gmrWrAddr,
  input  logic [KEY_W-1:0]          gmrWrData,
  input  logic                      srchValid,
  input  logic [DB_W-1:0]           srchDb,
  input  logic [KEY_W-1:0]          srchKey,
  input  logic [GSEL_W-1:0]         srchGmrSel,
  output logic                      resValid,
  output logic                      resHit,
  output logic                      resMultiHit,
  output logic [ROW_IDX_W-1:0]      resIndex,
  output logic [ROW_IDX_W-1:0]      resRelIndex
);
  tcmStrobe_t                stb;
  logic [NUM_ROWS*ROW_W-1:0] rowDataFlat;
  logic [NUM_ROWS*ROW_W-1:0] rowMaskFlat;
  logic [NUM_ROWS-1:0]       rowValidVec;
  logic [GMR_IDX_W-1:0]      gmrRdIdx;
  logic [KEY_W-1:0]          gmrRdData;

  tcm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rowWrEn(rowWrEn), .gmrWrEn(gmrWrEn),
    .srchValid(srchValid), .stb(stb), .resValid(resValid)
  );

  tcm_store #(
    .ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS), .KEY_W(KEY_W), .NUM_GMR(2*GMR_PER_HALF)
  ) u_store (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rowWrAddr(rowWrAddr), .rowWrData(rowWrData), .rowWrMask(rowWrMask),
    .rowWrValid(rowWrValid), .gmrWrAddr(gmrWrAddr), .gmrWrData(gmrWrData),
    .gmrRdIdx(gmrRdIdx), .rowDataFlat(rowDataFlat), .rowMaskFlat(rowMaskFlat),
    .rowValidVec(rowValidVec), .gmrRdData(gmrRdData)
  );

  tcm_match #(
    .ROW_W(ROW_W), .SEG_ROWS(SEG_ROWS), .NUM_SEG(NUM_SEG), .NUM_DB(NUM_DB),
    .MAX_WIDE_LOG2(MAX_WIDE_LOG2), .GMR_PER_HALF(GMR_PER_HALF)
  ) u_match (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgSegEnable(cfgSegEnable), .cfgSegDb(cfgSegDb), .cfgDbWidth(cfgDbWidth),
    .cfgDbGmrHalf(cfgDbGmrHalf), .srchDb(srchDb), .srchKey(srchKey),
    .srchGmrSel(srchGmrSel), .rowDataFlat(rowDataFlat), .rowMaskFlat(rowMaskFlat),
    .rowValidVec(rowValidVec), .gmrRdData(gmrRdData), .gmrRdIdx(gmrRdIdx),
    .resHit(resHit), .resMultiHit(resMultiHit), .resIndex(resIndex),
    .resRelIndex(resRelIndex)
  );
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker
  import tcm_pkg::*;
#(
  parameter int SEG_ROWS      = 16,
  parameter int NUM_SEG       = 4,
  parameter int NUM_DB        = 4,
  parameter int MAX_WIDE_LOG2 = 4,
  localparam int NUM_ROWS  = NUM_SEG * SEG_ROWS,
  localparam int ROW_IDX_W = $clog2(NUM_ROWS),
  localparam int DB_W      = (NUM_DB > 1) ? $clog2(NUM_DB) : 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_SEG-1:0]        cfgSegEnable,
  input logic [NUM_SEG*DB_W-1:0]   cfgSegDb,
  input logic [NUM_DB*WCODE_W-1:0] cfgDbWidth,
  input logic                      srchValid,
  input logic [DB_W-1:0]           srchDb,
  input logic                      resValid,
  input logic                      resHit,
  input logic                      resMultiHit,
  input logic [ROW_IDX_W-1:0]      resIndex,
  input logic [ROW_IDX_W-1:0]      resRelIndex
);
  logic [DB_W-1:0] dbD1, dbD2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbD1 <= '0;
      dbD2 <= '0;
    end else begin
      dbD1 <= srchDb;
      dbD2 <= dbD1;
    end
  end

  int              resSeg;
  logic [DB_W-1:0] resOwner;
  int              resMode;
  logic            aligned;
  always_comb begin
    resSeg   = int'(resIndex) / SEG_ROWS;
    resOwner = cfgSegDb[resSeg*DB_W +: DB_W];
    resMode  = int'(cfgDbWidth[int'(resOwner)*WCODE_W +: WCODE_W]);
    aligned  = (resMode <= MAX_WIDE_LOG2) && ((int'(resIndex) % (1 << resMode)) == 0);
  end

  p_owner_seg_r1: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit) |-> (cfgSegEnable[resSeg] && resOwner == dbD2))
    else $error("winner outside searched database");

  p_entry_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit) |-> aligned)
    else $error("winner not on an entry boundary");

  p_multi_needs_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resMultiHit) |-> resHit)
    else $error("multi-hit without hit");

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resIndex == '0 && resRelIndex == '0 && !resMultiHit))
    else $error("miss with nonzero fields");

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    srchValid |=> ##1 resValid)
    else $error("result missing two edges after search");

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    !srchValid |=> ##1 !resValid)
    else $error("result without search");

  p_rel_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit) |-> (resRelIndex <= resIndex))
    else $error("relative index above absolute index");
endmodule

bind tern_match_engine tcm_checker #(
  .SEG_ROWS(SEG_ROWS), .NUM_SEG(NUM_SEG), .NUM_DB(NUM_DB), .MAX_WIDE_LOG2(MAX_WIDE_LOG2)
) u_tcmChecker (
  .clk(clk), .rstN(rstN), .cfgSegEnable(cfgSegEnable), .cfgSegDb(cfgSegDb),
  .cfgDbWidth(cfgDbWidth), .srchValid(srchValid), .srchDb(srchDb),
  .resValid(resValid), .resHit(resHit), .resMultiHit(resMultiHit),
  .resIndex(resIndex), .resRelIndex(resRelIndex)
);

// File: tb/tern_match_engine_test.sv
`timescale 1ns/1ps
module tern_match_engine_test;
  localparam int RW = 36;
  localparam int KW = 576;
  localparam int NR = 64;
  localparam int SR = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0]  cfgSegEnable;
  logic [7:0]  cfgSegDb;
  logic [11:0] cfgDbWidth;
  logic [3:0]  cfgDbGmrHalf;
  logic        rowWrEn = 1'b0;
  logic [5:0]  rowWrAddr = '0;
  logic [RW-1:0] rowWrData = '0, rowWrMask = '0;
  logic        rowWrValid = 1'b0;
  logic        gmrWrEn = 1'b0;
  logic [5:0]  gmrWrAddr = '0;
  logic [KW-1:0] gmrWrData = '0;
  logic        srchValid = 1'b0;
  logic [1:0]  srchDb = '0;
  logic [KW-1:0] srchKey = '0;
  logic [4:0]  srchGmrSel = '0;
  logic        resValid, resHit, resMultiHit;
  logic [5:0]  resIndex, resRelIndex;

  always #2 clk = ~clk;

  tern_match_engine uut (.*);

  // reference model state
  logic [RW-1:0] mData [NR];
  logic [RW-1:0] mMask [NR];
  bit            mValid [NR];
  logic [KW-1:0] mGmr [64];

  // staged request for the next step
  bit nRow, nRowV, nGmr, nSrch;
  int nRowA, nGmrA, nDb, nSel;
  logic [RW-1:0] nRowD, nRowM;
  logic [KW-1:0] nGmrD, nKey;

  // pending search and expected result
  bit pendValid;
  int pendDb, pendSel;
  logic [KW-1:0] pendKey;
  string pendTag, expTag, curTag;
  bit expValid, expHit, expMulti;
  int expIdx, expRel;

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [KW-1:0] k36(input logic [RW-1:0] x);
    return {{(KW-RW){1'b0}}, x};
  endfunction

  task automatic evalModel(input int db, input logic [KW-1:0] key, input int sel,
                           output bit hit, output bit multi, output int idx, output int rel);
    logic [KW-1:0] g;
    int rank, cnt, w, n, r;
    bit ok;
    g = (sel == 31) ? {KW{1'b1}} : mGmr[32*int'(cfgDbGmrHalf[db]) + sel];
    hit = 0; multi = 0; idx = 0; rel = 0; rank = 0; cnt = 0;
    for (int s = 0; s < 4; s++) begin
      if (cfgSegEnable[s] && int'(cfgSegDb[s*2 +: 2]) == db) begin
        w = int'(cfgDbWidth[db*3 +: 3]);
        if (w <= 4) begin
          n = 1 << w;
          for (int e = 0; e < SR; e += n) begin
            r = s*SR + e;
            ok = mValid[r];
            for (int k = 0; k < n; k++)
              if (((key[k*RW +: RW] ^ mData[r+k]) & mMask[r+k] & g[k*RW +: RW]) != '0) ok = 0;
            if (ok) begin
              cnt++;
              if (!hit) begin hit = 1; idx = r; rel = rank*SR + e; end
            end
          end
        end
        rank++;
      end
    end
    multi = (cnt > 1);
  endtask

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", expTag, what, got, exp);
    end
  endtask

  task automatic step();
    bit h, mu;
    int ix, rl;
    @(negedge clk);
    chk("resValid", int'(resValid), int'(expValid));
    if (expValid) begin
      chk("resHit", int'(resHit), int'(expHit));
      chk("resMultiHit", int'(resMultiHit), int'(expMulti));
      chk("resIndex", int'(resIndex), expIdx);
      chk("resRelIndex", int'(resRelIndex), expRel);
    end
    expValid = pendValid;
    expTag = pendTag;
    if (pendValid) begin
      evalModel(pendDb, pendKey, pendSel, h, mu, ix, rl);
      expHit = h; expMulti = mu; expIdx = ix; expRel = rl;
    end
    rowWrEn = nRow; rowWrAddr = 6'(nRowA); rowWrData = nRowD; rowWrMask = nRowM; rowWrValid = nRowV;
    gmrWrEn = nGmr; gmrWrAddr = 6'(nGmrA); gmrWrData = nGmrD;
    srchValid = nSrch; srchDb = 2'(nDb); srchKey = nKey; srchGmrSel = 5'(nSel);
    if (nRow) begin mData[nRowA] = nRowD; mMask[nRowA] = nRowM; mValid[nRowA] = nRowV; end
    if (nGmr) mGmr[nGmrA] = nGmrD;
    pendValid = nSrch; pendDb = nDb; pendKey = nKey; pendSel = nSel; pendTag = curTag;
    nRow = 0; nGmr = 0; nSrch = 0;
  endtask

  task automatic setRow(input int a, input logic [RW-1:0] d, input logic [RW-1:0] m, input bit v);
    nRow = 1; nRowA = a; nRowD = d; nRowM = m; nRowV = v;
  endtask
  task automatic setSrch(input int db, input logic [KW-1:0] key, input int sel);
    nSrch = 1; nDb = db; nKey = key; nSel = sel;
  endtask
  task automatic wrRow(input int a, input logic [RW-1:0] d, input logic [RW-1:0] m, input bit v);
    setRow(a, d, m, v); step();
  endtask
  task automatic search(input int db, input logic [KW-1:0] key, input int sel);
    setSrch(db, key, sel); step();
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] wk;
    logic [RW-1:0] ones;
    ones = '1;
    for (int r = 0; r < NR; r++) begin mData[r] = '0; mMask[r] = '0; mValid[r] = 0; end
    for (int g = 0; g < 64; g++) mGmr[g] = '1;
    nRow = 0; nGmr = 0; nSrch = 0; nRowA = 0; nGmrA = 0; nDb = 0; nSel = 0;
    nRowD = '0; nRowM = '0; nRowV = 0; nGmrD = '0; nKey = '0;
    pendValid = 0; expValid = 0; pendDb = 0; pendSel = 0; pendKey = '0;
    pendTag = "R9"; expTag = "R9"; curTag = "R9";
    cfgSegEnable = 4'b1111;
    cfgSegDb     = {2'd1, 2'd2, 2'd1, 2'd0};
    cfgDbWidth   = {3'd0, 3'd4, 3'd1, 3'd0};
    cfgDbGmrHalf = 4'b0001;

    // R9: reset holds result strobe low
    idle(3);
    rstN = 1'b1;
    idle(2);
    curTag = "R9"; search(0, k36(36'h0), 31);
    curTag = "R7"; search(3, k36(36'h5), 31);
    search(0, k36(36'hAB), 0);
    idle(2);

    // R3: ternary don't-care bits
    wrRow(0, 36'h0000000AB, ones, 1);
    wrRow(1, 36'h000000A00, 36'hFFFFFFF00, 1);
    curTag = "R3"; search(0, k36(36'h000000A55), 31);
    // R4 / R5: two matching rows, lowest wins
    curTag = "R5"; search(0, k36(36'h0000000AB), 31);
    wrRow(4, 36'h123456000, 36'hFFFFFF000, 1);
    wrRow(5, 36'h123400000, 36'hFFFF00000, 1);
    curTag = "R4"; search(0, k36(36'h123456789), 31);
    search(0, k36(36'h1234FF000), 31);

    // R8: same-cycle write seen, later write not seen
    curTag = "R8";
    setRow(6, 36'h000000777, ones, 1); setSrch(0, k36(36'h777), 31); step();
    setRow(6, 36'h000000777, ones, 0); setSrch(0, k36(36'h777), 31); step();
    search(0, k36(36'h777), 31);
    wrRow(6, 36'h000000777, ones, 1);
    idle(2);

    // R2: 72-bit entries across two rows
    wrRow(16, 36'h111, ones, 1);
    wrRow(17, 36'h222, ones, 1);
    curTag = "R2";
    search(1, {{(KW-72){1'b0}}, 36'h222, 36'h111}, 31);
    search(1, {{(KW-72){1'b0}}, 36'h223, 36'h111}, 31);
    wrRow(48, 36'h111, ones, 1);
    wrRow(49, 36'h222, ones, 1);
    curTag = "R5"; search(1, {{(KW-72){1'b0}}, 36'h222, 36'h111}, 31);
    wrRow(16, 36'h111, ones, 0);
    curTag = "R10"; search(1, {{(KW-72){1'b0}}, 36'h222, 36'h111}, 31);

    // R2: 576-bit entry in a single segment
    for (int k = 0; k < 16; k++) wrRow(32 + k, RW'(100 + k), ones, 1);
    for (int k = 0; k < 16; k++) wk[k*RW +: RW] = RW'(100 + k);
    curTag = "R2"; search(2, wk, 31);
    wk[15*RW +: RW] = 36'h0;
    search(2, wk, 31);

    // R6: global masks by half and reserved selector
    nGmr = 1; nGmrA = 34; nGmrD = {{(KW-RW){1'b1}}, 36'hFFFFFFF00}; step();
    nGmr = 1; nGmrA = 2;  nGmrD = '1; step();
    curTag = "R6";
    search(0, k36(36'h0CD), 2);
    search(0, k36(36'h0CD), 31);
    idle(3);
    cfgDbGmrHalf = 4'b0000;
    idle(1);
    search(0, k36(36'h0CD), 2);
    idle(3);

    // R1: segment enable and remap
    curTag = "R1";
    cfgSegEnable = 4'b0111;
    idle(1);
    search(1, {{(KW-72){1'b0}}, 36'h222, 36'h111}, 31);
    idle(3);
    cfgSegEnable = 4'b1111;
    cfgSegDb = {2'd3, 2'd2, 2'd1, 2'd0};
    idle(1);
    search(3, k36(36'h111), 31);
    search(1, {{(KW-72){1'b0}}, 36'h222, 36'h111}, 31);
    idle(3);
    cfgSegDb = {2'd1, 2'd2, 2'd1, 2'd0};
    cfgDbGmrHalf = 4'b0011;
    idle(1);

    // R4: mixed random traffic with dense overlaps
    curTag = "R4";
    nGmr = 1; nGmrA = 33; nGmrD = {{(KW-RW){1'b1}}, 36'hFFFFFFFFE}; step();
    for (int i = 0; i < 400; i++) begin
      int a, kind;
      kind = int'($urandom_range(0, 2));
      if (kind != 0) begin
        a = int'($urandom_range(0, 63));
        if (a >= 32 && a < 48) a = a - 16;
        setRow(a, RW'($urandom_range(0, 3)), {{(RW-2){1'b1}}, 2'($urandom_range(0, 3))},
               ($urandom_range(0, 4) != 0));
      end
      if (kind != 1) begin
        int db, sel;
        db = ($urandom_range(0, 1) == 0) ? 0 : 1;
        sel = ($urandom_range(0, 2) == 0) ? 31 : int'($urandom_range(0, 1));
        setSrch(db, {{(KW-72){1'b0}}, RW'($urandom_range(0, 3)), RW'($urandom_range(0, 3))}, sel);
      end
      step();
    end
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule